// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. A single pass of combinational logic handles each instruction. It fetches the word at the current program counter, splits it into fields and decodes the opcode into a control word. It then reads two source registers, computes a result in the ALU and selects both the write-back value and the next program counter. Every state element updates at the next rising edge: the program counter, the register file and the data memory.

The core implements ten instructions: add, addi, lw, sw, beq, j, sll, slt, jal and jr. The instruction memory and the data memory are word arrays inside the block. A loader port fills both memories while the core is held in reset. The current program counter, the register write strobe and the data memory write strobe are visible at the ports, so the core can be followed one instruction at a time.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, the core makes no register write and no memory write, and both write strobes stay low. After a rising edge with `rst` high, `pc_o` reads 0.
- R2: Every instruction that is not beq, j, jal or jr sets the next PC to PC+4.
- R3: Arithmetic instructions write their result to a register.
  - R-type instructions (opcode 0x00) write to rd. The fields are rs[25:21], rt[20:16], rd[15:11] and shamt[10:6].
  - add (funct 0x20) writes rs+rt.
  - sll (funct 0x00) writes rt shifted left by shamt.
  - slt (funct 0x2A) writes 1 when rs is less than rt as signed values, and 0 otherwise.
  - addi (opcode 0x08) writes rs plus the sign-extended imm[15:0] to rt.
- R4: Loads and stores use the byte address rs + sext(imm[15:0]). The data word index is address bits [7:2], taken modulo the memory depth.
  - lw (opcode 0x23) writes the addressed word to rt.
  - sw (opcode 0x2B) writes rt to the addressed word and makes no register write.
- R5: beq (opcode 0x04) makes no writes. When rs equals rt, it sets the next PC to PC+4 + (sext(imm) << 2). Otherwise the next PC is PC+4.
- R6: j (opcode 0x02) and jal (opcode 0x03) set the next PC to {PC+4[31:28], target[25:0], 2'b00}. jal also writes PC+4 to register 31.
- R7: jr (R-type with funct 0x08) sets the next PC to the value of register rs and makes no writes.
- R8: Register 0 always reads as zero. A write addressed to register 0 has no effect.
- R9: Any other opcode, and any R-type instruction with a funct not listed above, makes no writes and advances the PC by 4.
- R10: The instruction is fetched from word index PC[7:2] of the instruction memory. A PC beyond the memory therefore wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Loader write strobe |
| load_to_dmem | input | 1 | Loader target: 1 selects data memory, 0 selects instruction memory |
| load_addr | input | 6 | Loader word index |
| load_data | input | 32 | Loader write word |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register write strobe for the current instruction |
| rf_waddr_o | output | 5 | Destination register index |
| rf_wdata_o | output | 32 | Write-back value |
| dm_we_o | output | 1 | Data memory write strobe |
| dm_addr_o | output | 32 | Data memory byte address |
| dm_wdata_o | output | 32 | Data memory write value |

## Verification
Every instruction shows its effect on the write strobes in the same cycle and on `pc_o` one edge later. A wrong decode or a wrong next-PC choice is therefore seen at the very next check. A corrupted register, including one written through register 0, stays hidden until an instruction reads it. The bench therefore mixes short random programs that reuse a few registers heavily with a directed program in which every value is read back soon after it is written. A misplaced store shows up at the first later load from that word.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int DW   = 32;
    localparam int NREG = 32;
    localparam int RAW  = $clog2(NREG);

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] OP_JAL   = 6'h03;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SLL = 6'h00;
    localparam logic [5:0] FN_SLT = 6'h2A;
    localparam logic [5:0] FN_JR  = 6'h08;

    localparam logic [RAW-1:0] LINK_REG = RAW'(NREG - 1);

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLL} alu_e;
    typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dst_e;
    typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_CMP, WB_LINK} wb_e;
    typedef enum logic [1:0] {PC_SEQ, PC_BR, PC_JMP, PC_REG} pcsel_e;

    typedef struct packed {
        logic [5:0]     op;
        logic [RAW-1:0] rs;
        logic [RAW-1:0] rt;
        logic [RAW-1:0] rd;
        logic [4:0]     sh;
        logic [5:0]     fn;
        logic [15:0]    imm;
        logic [25:0]    tgt;
    } insn_t;

    typedef struct packed {
        logic   rf_we;
        dst_e   dst;
        wb_e    wb;
        logic   alu_imm;
        alu_e   alu;
        logic   dm_we;
        pcsel_e pcsel;
    } ctrl_t;

    function automatic insn_t split_insn(input logic [DW-1:0] w);
        insn_t f;
        f.op  = w[31:26];
        f.rs  = w[25:21];
        f.rt  = w[20:16];
        f.rd  = w[15:11];
        f.sh  = w[10:6];
        f.fn  = w[5:0];
        f.imm = w[15:0];
        f.tgt = w[25:0];
        return f;
    endfunction

    function automatic logic [DW-1:0] sext16(input logic [15:0] v);
        return {{(DW-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_core_pkg::*;
(
    input  insn_t f,
    output ctrl_t c,
    output logic  illegal
);
    localparam ctrl_t IDLE = '{rf_we: 1'b0, dst: DST_RT, wb: WB_ALU, alu_imm: 1'b0,
                               alu: ALU_ADD, dm_we: 1'b0, pcsel: PC_SEQ};

    always_comb begin
        c       = IDLE;
        illegal = 1'b0;
        unique case (f.op)
            OP_RTYPE: begin
                c.dst = DST_RD;
                case (f.fn)
                    FN_ADD: c.rf_we = 1'b1;
                    FN_SLL: begin c.rf_we = 1'b1; c.alu = ALU_SLL; end
                    FN_SLT: begin c.rf_we = 1'b1; c.alu = ALU_SUB; c.wb = WB_CMP; end
                    FN_JR:  c.pcsel = PC_REG;
                    default: illegal = 1'b1;
                endcase
            end
            OP_ADDI: begin c.rf_we = 1'b1; c.alu_imm = 1'b1; end
            OP_LW:   begin c.rf_we = 1'b1; c.alu_imm = 1'b1; c.wb = WB_MEM; end
            OP_SW:   begin c.dm_we = 1'b1; c.alu_imm = 1'b1; end
            OP_BEQ:  begin c.alu = ALU_SUB; c.pcsel = PC_BR; end
            OP_J:    c.pcsel = PC_JMP;
            OP_JAL:  begin
                c.pcsel = PC_JMP; c.rf_we = 1'b1; c.dst = DST_LINK; c.wb = WB_LINK;
            end
            default: illegal = 1'b1;
        endcase
    end

    // R9: an undecoded word must leave every write strobe idle
    always_comb begin
        if (illegal)
            a_r9_idle: assert (!c.rf_we && !c.dm_we && c.pcsel == PC_SEQ);
    end

    // R6: jump-and-link routes the return address to the link register
    always_comb begin
        if (f.op == OP_JAL)
            a_r6_link: assert (c.wb == WB_LINK && c.dst == DST_LINK && c.rf_we);
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [4:0]    shamt,
    input  alu_e          op,
    output logic [DW-1:0] y,
    output logic          zero,
    output logic          lt
);
    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_SLL: y = b << shamt;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
    assign lt   = ($signed(a) < $signed(b));

    // R5: the zero flag of a subtraction must mean equal operands
    always_comb begin
        if (op == ALU_SUB)
            a_r5_zero_eq: assert (zero == (a == b));
    end
endmodule

// File: rtl/sc_regs.sv
module sc_regs
    import sc_core_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [RAW-1:0] ra1,
    input  logic [RAW-1:0] ra2,
    output logic [DW-1:0]  rd1,
    output logic [DW-1:0]  rd2
);
    logic [DW-1:0]   regs [NREG];
    logic [NREG-1:0] row_we;

    // per-row enable: decoded index AND global strobe; row 0 never enabled
    assign row_we[0] = 1'b0;
    for (genvar i = 1; i < NREG; i++) begin : g_row
        assign row_we[i] = we && (waddr == RAW'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            for (int i = 1; i < NREG; i++)
                if (row_we[i]) regs[i] <= wdata;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];

    // R8: row 0 keeps zero whatever is written
    a_r8_r0_hold: assert property (@(posedge clk) disable iff (rst)
        regs[0] == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int MEM_WORDS = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load_en,
    input  logic                         load_to_dmem,
    input  logic [$clog2(MEM_WORDS)-1:0] load_addr,
    input  logic [31:0]                  load_data,
    output logic [31:0]                  pc_o,
    output logic                         rf_we_o,
    output logic [4:0]                   rf_waddr_o,
    output logic [31:0]                  rf_wdata_o,
    output logic                         dm_we_o,
    output logic [31:0]                  dm_addr_o,
    output logic [31:0]                  dm_wdata_o
);
    localparam int            MAW     = $clog2(MEM_WORDS);
    localparam logic [DW-1:0] PC_STEP = DW'(4);

    logic [DW-1:0] imem [MEM_WORDS];
    logic [DW-1:0] dmem [MEM_WORDS];

    logic [DW-1:0]  pc_q, pc_next, pc_plus4, br_tgt, jmp_tgt;
    logic [DW-1:0]  insn, imm_x, rd1, rd2, alu_b, alu_y, mem_rd, wdata;
    logic [RAW-1:0] waddr;
    logic           zero, lt, illegal, rf_we, dm_we;
    logic [MAW-1:0] dm_idx;
    insn_t          f;
    ctrl_t          ctl;

    // fetch and decode
    assign insn = imem[pc_q[MAW+1:2]];
    assign f    = split_insn(insn);

    sc_ctrl u_ctrl (.f(f), .c(ctl), .illegal(illegal));

    sc_regs u_regs (
        .clk(clk), .rst(rst), .we(rf_we), .waddr(waddr), .wdata(wdata),
        .ra1(f.rs), .ra2(f.rt), .rd1(rd1), .rd2(rd2)
    );

    assign imm_x = sext16(f.imm);
    assign alu_b = ctl.alu_imm ? imm_x : rd2;

    sc_alu u_alu (
        .a(rd1), .b(alu_b), .shamt(f.sh), .op(ctl.alu),
        .y(alu_y), .zero(zero), .lt(lt)
    );

    // memories
    assign dm_idx = alu_y[MAW+1:2];
    assign mem_rd = dmem[dm_idx];

    always_ff @(posedge clk) begin
        if (load_en && !load_to_dmem) imem[load_addr] <= load_data;
    end

    always_ff @(posedge clk) begin
        if (load_en && load_to_dmem) dmem[load_addr] <= load_data;
        else if (dm_we)              dmem[dm_idx]    <= rd2;
    end

    // write-back
    always_comb begin
        unique case (ctl.dst)
            DST_RD:   waddr = f.rd;
            DST_LINK: waddr = LINK_REG;
            default:  waddr = f.rt;
        endcase
    end

    always_comb begin
        unique case (ctl.wb)
            WB_MEM:  wdata = mem_rd;
            WB_CMP:  wdata = {{(DW-1){1'b0}}, lt};
            WB_LINK: wdata = pc_plus4;
            default: wdata = alu_y;
        endcase
    end

    assign rf_we = ctl.rf_we && !rst;
    assign dm_we = ctl.dm_we && !rst;

    // next PC
    assign pc_plus4 = pc_q + PC_STEP;
    assign br_tgt   = pc_plus4 + {imm_x[DW-3:0], 2'b00};
    assign jmp_tgt  = {pc_plus4[DW-1:DW-4], f.tgt, 2'b00};

    always_comb begin
        unique case (ctl.pcsel)
            PC_BR:   pc_next = zero ? br_tgt : pc_plus4;
            PC_JMP:  pc_next = jmp_tgt;
            PC_REG:  pc_next = rd1;
            default: pc_next = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o       = pc_q;
    assign rf_we_o    = rf_we;
    assign rf_waddr_o = waddr;
    assign rf_wdata_o = wdata;
    assign dm_we_o    = dm_we;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rd2;

    // R1: reset parks the PC at zero
    a_r1_pc_reset: assert property (@(posedge clk) rst |=> pc_q == '0);

    // R2: plain instructions step by one word
    a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
        ctl.pcsel == PC_SEQ |=> pc_q == $past(pc_q) + PC_STEP);

    // R4: a store never writes a register
    a_r4_store_quiet: assert property (@(posedge clk) disable iff (rst)
        dm_we |-> !rf_we);

    // R7: register jumps land on the value read from rs
    a_r7_jr_follow: assert property (@(posedge clk) disable iff (rst)
        ctl.pcsel == PC_REG |=> pc_q == $past(rd1));
endmodule

// File: tb/tb_sc_core.sv
module tb_sc_core;
    localparam int WORDS = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic        load_to_dmem = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]  rf_waddr_o;
    logic        rf_we_o, dm_we_o;

    always #5 clk = ~clk;

    sc_core #(.MEM_WORDS(WORDS)) dut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_to_dmem(load_to_dmem),
        .load_addr(load_addr), .load_data(load_data), .pc_o(pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] m_pc;
    logic [31:0] m_rf [32];
    logic [31:0] m_dm [WORDS];
    logic [31:0] m_im [WORDS];
    string       pc_tag;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt,
                                          input int rd, input int sh);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                          input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [5:0] op, input int tgt);
        return {op, 26'(tgt)};
    endfunction

    function automatic logic [31:0] rand_ins();
        int k  = int'($urandom % 12);
        int rs = int'($urandom % 8);
        int rt = int'($urandom % 8);
        int rd = int'($urandom % 9);
        if (rd == 8) rd = 31;
        case (k)
            0, 1: return enc_r(6'h20, rs, rt, rd, 0);
            2:    return enc_r(6'h00, rs, rt, rd, int'($urandom % 32));
            3:    return enc_r(6'h2A, rs, rt, rd, 0);
            4, 5: return enc_i(6'h08, rs, rt, 16'($urandom));
            6:    return enc_i(6'h23, rs, rt, 16'($urandom % 512));
            7:    return enc_i(6'h2B, rs, rt, 16'($urandom % 512));
            8:    return enc_i(6'h04, rs, rt, 16'(int'($urandom % 17) - 8));
            9:    return enc_j(($urandom % 2) ? 6'h03 : 6'h02, int'($urandom % 72));
            10:   return enc_r(6'h08, ($urandom % 2) ? 31 : rs, 0, 0, 0);
            default: return ($urandom % 2) ? 32'hFC00_0000 : enc_r(6'h3F, rs, rt, rd, 0);
        endcase
    endfunction

    // reference step: expected outputs of the current instruction, then commit
    task automatic step_check();
        logic [31:0] w, rsv, rtv, sx, pc4, nxt, wd, da, dd;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd, sh, wa;
        bit          we, dwe, bad_op;
        string       tg, ntag;
        w  = m_im[m_pc[7:2]];
        op = w[31:26]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11];
        sh = w[10:6];  fn = w[5:0];
        rsv = m_rf[rs]; rtv = m_rf[rt];
        sx  = {{16{w[15]}}, w[15:0]};
        pc4 = m_pc + 32'd4;
        nxt = pc4; we = 0; dwe = 0; wa = 0; wd = 0; da = 0; dd = 0; bad_op = 0;
        tg = "R3"; ntag = "R2";
        case (op)
            6'h00: begin
                wa = rd;
                case (fn)
                    6'h20: begin we = 1; wd = rsv + rtv; end
                    6'h00: begin we = 1; wd = rtv << sh; end
                    6'h2A: begin we = 1; wd = ($signed(rsv) < $signed(rtv)) ? 32'd1 : 32'd0; end
                    6'h08: begin nxt = rsv; ntag = "R7"; tg = "R7"; end
                    default: bad_op = 1;
                endcase
            end
            6'h08: begin we = 1; wa = rt; wd = rsv + sx; end
            6'h23: begin we = 1; wa = rt; da = rsv + sx; wd = m_dm[da[7:2]]; tg = "R4"; end
            6'h2B: begin dwe = 1; da = rsv + sx; dd = rtv; tg = "R4"; end
            6'h04: begin
                tg = "R5"; ntag = "R5";
                if (rsv == rtv) nxt = pc4 + {sx[29:0], 2'b00};
            end
            6'h02, 6'h03: begin
                tg = "R6"; ntag = "R6";
                nxt = {pc4[31:28], w[25:0], 2'b00};
                if (op == 6'h03) begin we = 1; wa = 5'd31; wd = pc4; end
            end
            default: bad_op = 1;
        endcase
        if (bad_op) begin tg = "R9"; ntag = "R9"; end
        else if (we && (rs == 0 || rt == 0)) tg = "R8";
        if (m_pc >= 32'(WORDS * 4)) tg = "R10";

        chk(pc_o == m_pc, pc_tag, "pc", pc_o, m_pc);
        chk(rf_we_o == we, tg, "rf_we", 32'(rf_we_o), 32'(we));
        if (we && rf_we_o) begin
            chk(rf_waddr_o == wa, tg, "rf_waddr", 32'(rf_waddr_o), 32'(wa));
            chk(rf_wdata_o == wd, tg, "rf_wdata", rf_wdata_o, wd);
        end
        chk(dm_we_o == dwe, tg, "dm_we", 32'(dm_we_o), 32'(dwe));
        if (dwe && dm_we_o) begin
            chk(dm_addr_o == da, tg, "dm_addr", dm_addr_o, da);
            chk(dm_wdata_o == dd, tg, "dm_wdata", dm_wdata_o, dd);
        end

        if (we && wa != 0) m_rf[wa] = wd;   // R8: writes to r0 are dropped
        if (dwe) m_dm[da[7:2]] = dd;
        m_pc   = nxt;
        pc_tag = ntag;
    endtask

    task automatic run_prog(input int ncyc);
        rst = 1'b1;
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        for (int i = 0; i < 2 * WORDS; i++) begin
            @(negedge clk);
            load_en      = 1'b1;
            load_to_dmem = (i >= WORDS);
            load_addr    = 6'(i % WORDS);
            load_data    = (i >= WORDS) ? m_dm[i - WORDS] : m_im[i];
            #1;
            // R1: no writes while reset is held
            chk(!rf_we_o && !dm_we_o, "R1", "strobes in reset",
                {30'b0, rf_we_o, dm_we_o}, 32'd0);
        end
        @(negedge clk);
        load_en = 1'b0;
        #1;
        chk(pc_o == 32'd0, "R1", "pc after reset", pc_o, 32'd0);
        m_pc   = '0;
        pc_tag = "R1";
        rst    = 1'b0;
        for (int c = 0; c < ncyc; c++) begin
            #1;
            step_check();
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd20250601));
        // directed program
        for (int i = 0; i < WORDS; i++) begin m_im[i] = '0; m_dm[i] = 32'(i * 3); end
        m_im[0]  = enc_i(6'h08, 0, 1, 16'hFFFD);   // r1 = -3
        m_im[1]  = enc_i(6'h08, 0, 2, 16'd5);      // r2 = 5
        m_im[2]  = enc_r(6'h2A, 1, 2, 3, 0);       // slt -> 1, signed
        m_im[3]  = enc_r(6'h2A, 2, 1, 4, 0);       // slt -> 0
        m_im[4]  = enc_r(6'h20, 1, 2, 0, 0);       // write to r0, dropped
        m_im[5]  = enc_r(6'h20, 0, 2, 5, 0);       // r5 = 0 + 5
        m_im[6]  = enc_r(6'h00, 0, 2, 6, 4);       // sll -> 80
        m_im[7]  = enc_i(6'h2B, 0, 6, 16'd8);      // store to word 2
        m_im[8]  = enc_i(6'h23, 0, 7, 16'd8);      // load it back
        m_im[9]  = enc_i(6'h04, 5, 2, 16'd1);      // taken, skips 10
        m_im[10] = enc_i(6'h08, 0, 8, 16'd1);
        m_im[11] = enc_i(6'h04, 1, 2, 16'd5);      // not taken
        m_im[12] = enc_j(6'h03, 20);               // jal -> word 20
        m_im[13] = 32'hFC00_0000;                  // undecoded opcode
        m_im[14] = enc_j(6'h02, 64);               // j past the end -> wraps
        m_im[20] = enc_r(6'h20, 1, 2, 9, 0);
        m_im[21] = enc_r(6'h08, 31, 0, 0, 0);      // jr r31 -> word 13
        run_prog(60);
        // random programs
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < WORDS; i++) begin
                m_im[i] = rand_ins();
                m_dm[i] = $urandom;
            end
            run_prog(400);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule